// File: doc/BRIEF.md
# Masked Interrupt Priority Resolver

This block gathers interrupt requests from four onboard peripherals and from sixteen card-level request sources. Each card-level source is steered by a two-bit routing field onto one of four channel lines, and each line is the OR of the sources routed to it. The four onboard sources and the four channel lines make eight prioritised sources. The block gates them with per-source enables and one global enable, then reports the highest level that is still eligible to the processor as a 3-bit priority level.

When the processor acknowledges a level, the block returns the 8-bit vector of the winning source at that level. Software loads the enables through a single-word write port. Out of reset every enable is cleared, so no request reaches the processor until software opens the gates. The enables are active-low masks: a bit value of 1 allows a source through, and a value of 0 masks it.

Source index order is fixed. Indices 0 to 3 are the onboard clock tick, serial receive-ready, serial transmit-ready and MMU fault. Indices 4 to 7 are channel lines 1 to 4.

Top module: `irq_prioritizer`

## Requirements
- R1: After reset every mask bit is asserted (register value 0), so `ipl` stays 0 whatever the request inputs are.
- R2: A cycle with `mask_we` high loads `mask_wdata` into the mask register. Bit 0 is the global enable. Bit i+1 enables source index i. A load changes `ipl` two clock edges after the write edge, and the register holds its value while `mask_we` is low.
- R3: While global bit 0 is 0, no source is eligible and `ipl` is 0, whatever the per-source bits are.
- R4: Clearing a source's bit removes a request that is already asserted from `ipl`. Setting the bit again while the request is still held makes it eligible again.
- R5: Sub-source j is routed by `sub_route[2j+1:2j]`, where value k selects channel line k+1. A line is pending while any sub-source routed to it is high, and it drops as soon as none is.
- R6: Channel lines 1, 2, 3 and 4 carry levels 2, 4, 5 and 6.
- R7: `ipl` equals the highest level among eligible sources, or 0 when none is eligible. An input change sampled at one edge is visible after the next edge.
- R8: When acknowledged, channel lines 1 to 4 return vectors 0x41, 0x43, 0x44 and 0x45. By default the onboard sources (clock, receive, transmit, MMU) have levels 6, 5, 5 and 7 and vectors 0x48, 0x49, 0x4A and 0x4B.
- R9: When several eligible sources share the acknowledged level, the source with the lowest index supplies the vector.
- R10: With `iack` high and no eligible source at `iack_lvl`, `iack_vec` is the spurious vector 0x18. With `iack` low, `iack_vec` is 0.
- R11: Channel pending state is rebuilt every cycle. Re-routing an asserted sub-source moves its request to the new line, and the line is released once the source drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 9 | Mask word: bit 0 global, bits 1..8 per source |
| ob_req | input | 4 | Onboard requests: clock, receive, transmit, MMU |
| sub_req | input | 16 | Card-level request sources |
| sub_route | input | 32 | Two-bit channel select per sub-source |
| ipl | output | 3 | Highest eligible priority level |
| iack | input | 1 | Acknowledge cycle active |
| iack_lvl | input | 3 | Level being acknowledged |
| iack_vec | output | 8 | Vector returned for the acknowledge |

## Verification
The hardest case to reach is a request that is already asserted when its mask is set, and that must come back when the mask is cleared while the request is still held. The bench raises the MMU fault first and confirms level 7. It then rewrites only that source's bit while the input stays high, and expects the level to fall to the next eligible source before returning to 7. A sub-source is also re-routed while it is asserted, which checks that neither the old line nor the new one is left stuck once the sub-source drops.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int N_OB     = 4;
    localparam int N_CH     = 4;
    localparam int N_SRC    = N_OB + N_CH;
    localparam int MASK_W   = N_SRC + 1;
    localparam int LVL_W    = 3;
    localparam int VEC_W    = 8;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        lvl_t lvl;
        vec_t vec;
    } src_attr_t;

    function automatic lvl_t chan_level(input int c);
        case (c)
            0:       return lvl_t'(2);
            1:       return lvl_t'(4);
            2:       return lvl_t'(5);
            default: return lvl_t'(6);
        endcase
    endfunction

    function automatic vec_t chan_vector(input int c);
        case (c)
            0:       return vec_t'(8'h41);
            1:       return vec_t'(8'h43);
            2:       return vec_t'(8'h44);
            default: return vec_t'(8'h45);
        endcase
    endfunction

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = irq_pkg::MASK_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (we)
            mask_q <= wdata;
    end

    a_r2_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mask_q));

    a_r2_mask_load: assert property (@(posedge clk) disable iff (rst)
        we |=> mask_q == $past(wdata));

endmodule

// File: rtl/irq_chan_merge.sv
module irq_chan_merge #(
    parameter int N_SUB = 16,
    parameter int N_CH  = irq_pkg::N_CH,
    localparam int RW   = $clog2(N_CH)
) (
    input  logic [N_SUB-1:0]    sub_req,
    input  logic [N_SUB*RW-1:0] sub_route,
    output logic [N_CH-1:0]     line
);

    for (genvar c = 0; c < N_CH; c++) begin : g_line
        logic [N_SUB-1:0] hit;
        always_comb begin
            for (int j = 0; j < N_SUB; j++)
                hit[j] = sub_req[j] && (sub_route[j*RW +: RW] == RW'(c));
        end
        assign line[c] = |hit;
    end

endmodule

// File: rtl/irq_level_resolve.sv
module irq_level_resolve #(
    parameter int            NS       = irq_pkg::N_SRC,
    parameter irq_pkg::vec_t SPUR_VEC = 8'h18
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NS-1:0]                  elig,
    input  irq_pkg::src_attr_t [NS-1:0]    attr,
    input  logic                           ack,
    input  irq_pkg::lvl_t                  ack_lvl,
    output irq_pkg::lvl_t                  ipl,
    output irq_pkg::vec_t                  vec
);
    import irq_pkg::*;

    logic hit;
    vec_t pick;

    always_comb begin
        ipl = '0;
        for (int i = 0; i < NS; i++)
            if (elig[i] && attr[i].lvl > ipl)
                ipl = attr[i].lvl;
    end

    always_comb begin
        hit  = 1'b0;
        pick = SPUR_VEC;
        for (int i = NS - 1; i >= 0; i--) begin
            if (elig[i] && attr[i].lvl == ack_lvl) begin
                hit  = 1'b1;
                pick = attr[i].vec;
            end
        end
        vec = ack ? pick : '0;
    end

    for (genvar i = 0; i < NS; i++) begin : g_chk
        a_r7_ipl_covers: assert property (@(posedge clk) disable iff (rst)
            elig[i] |-> ipl >= attr[i].lvl);
    end

    a_r9_ack_top_hits: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_lvl == ipl && ipl != '0) |-> hit);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !ack |-> vec == '0);

endmodule

// File: rtl/irq_prioritizer.sv
module irq_prioritizer #(
    parameter int                          N_SUB    = 16,
    parameter logic [irq_pkg::N_OB*3-1:0]  OB_LVL   = {3'd7, 3'd5, 3'd5, 3'd6},
    parameter logic [irq_pkg::N_OB*8-1:0]  OB_VEC   = {8'h4B, 8'h4A, 8'h49, 8'h48},
    parameter logic [7:0]                  SPUR_VEC = 8'h18,
    localparam int RW = $clog2(irq_pkg::N_CH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       mask_we,
    input  logic [irq_pkg::MASK_W-1:0] mask_wdata,
    input  logic [irq_pkg::N_OB-1:0]   ob_req,
    input  logic [N_SUB-1:0]           sub_req,
    input  logic [N_SUB*RW-1:0]        sub_route,
    output logic [2:0]                 ipl,
    input  logic                       iack,
    input  logic [2:0]                 iack_lvl,
    output logic [7:0]                 iack_vec
);
    import irq_pkg::*;

    logic [MASK_W-1:0] mask_q;
    logic [N_CH-1:0]   line;
    logic [N_SRC-1:0]  req_all;
    logic [N_SRC-1:0]  elig_q;
    src_attr_t [N_SRC-1:0] attr;

    irq_mask_reg #(.W(MASK_W)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .we     (mask_we),
        .wdata  (mask_wdata),
        .mask_q (mask_q)
    );

    irq_chan_merge #(.N_SUB(N_SUB), .N_CH(N_CH)) u_merge (
        .sub_req   (sub_req),
        .sub_route (sub_route),
        .line      (line)
    );

    for (genvar i = 0; i < N_OB; i++) begin : g_ob_attr
        assign attr[i].lvl = OB_LVL[i*3 +: 3];
        assign attr[i].vec = OB_VEC[i*8 +: 8];
    end
    for (genvar c = 0; c < N_CH; c++) begin : g_ch_attr
        assign attr[N_OB+c].lvl = chan_level(c);
        assign attr[N_OB+c].vec = chan_vector(c);
    end

    assign req_all = {line, ob_req};

    always_ff @(posedge clk) begin
        if (rst)
            elig_q <= '0;
        else
            elig_q <= req_all & mask_q[N_SRC:1] & {N_SRC{mask_q[0]}};
    end

    irq_level_resolve #(.NS(N_SRC), .SPUR_VEC(SPUR_VEC)) u_res (
        .clk     (clk),
        .rst     (rst),
        .elig    (elig_q),
        .attr    (attr),
        .ack     (iack),
        .ack_lvl (iack_lvl),
        .ipl     (ipl),
        .vec     (iack_vec)
    );

    a_r3_global_blocks: assert property (@(posedge clk) disable iff (rst)
        !mask_q[0] |=> elig_q == '0);

    for (genvar i = 0; i < N_SRC; i++) begin : g_mask_chk
        a_r4_src_masked: assert property (@(posedge clk) disable iff (rst)
            !mask_q[i+1] |=> !elig_q[i]);
    end

    a_r5_lines_drop: assert property (@(posedge clk) disable iff (rst)
        !(|sub_req) |=> elig_q[N_SRC-1:N_OB] == '0);

    a_r7_idle_level: assert property (@(posedge clk) disable iff (rst)
        !(|ob_req) && !(|sub_req) |=> ipl == '0);

endmodule

// File: tb/tb_irq_prioritizer.sv
module tb_irq_prioritizer;

    logic        clk = 1'b0;
    logic        rst;
    logic        mask_we;
    logic [8:0]  mask_wdata;
    logic [3:0]  ob_req;
    logic [15:0] sub_req;
    logic [31:0] sub_route;
    logic [2:0]  ipl;
    logic        iack;
    logic [2:0]  iack_lvl;
    logic [7:0]  iack_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_prioritizer dut (
        .clk(clk), .rst(rst), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .ob_req(ob_req), .sub_req(sub_req), .sub_route(sub_route),
        .ipl(ipl), .iack(iack), .iack_lvl(iack_lvl), .iack_vec(iack_vec)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic set_mask(input logic [8:0] m);
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_we = 1'b0;
        settle();
    endtask

    task automatic ack_chk(input string tag, input int lvl, input int exp);
        iack = 1'b1; iack_lvl = 3'(lvl);
        #1;
        chk(tag, iack_vec, exp);
        iack = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        ob_req = '1; sub_req = '1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        chk("R1 reset masks hold ipl at 0", ipl, 0);
        ob_req = '0; sub_req = '0;
        set_mask(9'h1FF);
        chk("R7 all open, no request", ipl, 0);
    endtask

    task automatic t_channels();
        sub_route = '0;
        sub_req = 16'h0001; settle();
        chk("R6 line1 level", ipl, 2);
        ack_chk("R8 line1 vector", 2, 8'h41);
        sub_route[11:10] = 2'd3; sub_req = 16'h0020; settle();
        chk("R5 route to line4 level", ipl, 6);
        ack_chk("R8 line4 vector", 6, 8'h45);
        sub_route[11:10] = 2'd1; settle();
        chk("R11 reroute to line2", ipl, 4);
        ack_chk("R8 line2 vector", 4, 8'h43);
        sub_req = '0; settle();
        chk("R11 line released after drop", ipl, 0);
        sub_route[5:4] = 2'd2; sub_route[7:6] = 2'd2;
        sub_req = 16'h000C; settle();
        chk("R6 line3 level", ipl, 5);
        ack_chk("R8 line3 vector", 5, 8'h44);
        sub_req = 16'h0008; settle();
        chk("R5 line3 held by other source", ipl, 5);
        sub_req = '0; settle();
        chk("R5 line3 clears", ipl, 0);
    endtask

    task automatic t_priority();
        sub_route = '0; sub_route[11:10] = 2'd3;
        sub_req = 16'h0020; ob_req = 4'b0001; settle();
        chk("R7 clock with line4 level", ipl, 6);
        ack_chk("R9 tie lowest index clock", 6, 8'h48);
        ob_req = 4'b0000; sub_req = '0;
        sub_route[5:4] = 2'd2; sub_req = 16'h0004;
        ob_req = 4'b0110; settle();
        ack_chk("R9 tie receive wins", 5, 8'h49);
        ob_req = 4'b0100; settle();
        ack_chk("R8 transmit vector", 5, 8'h4A);
        ack_chk("R10 spurious at empty level", 3, 8'h18);
        #1;
        chk("R10 idle vector zero", iack_vec, 0);
        ob_req = '0; sub_req = '0; settle();
    endtask

    task automatic t_masks();
        ob_req = 4'b1001; settle();
        chk("R8 MMU level 7", ipl, 7);
        ack_chk("R8 MMU vector", 7, 8'h4B);
        set_mask(9'h1EF);
        chk("R4 MMU masked while held", ipl, 6);
        set_mask(9'h1FF);
        chk("R4 MMU returns when unmasked", ipl, 7);
        set_mask(9'h1FE);
        chk("R3 global blocks all", ipl, 0);
        @(negedge clk); @(negedge clk);
        chk("R2 register holds without write", ipl, 0);
        set_mask(9'h1FF);
        chk("R2 reopen", ipl, 7);
        ob_req = '0; settle();
    endtask

    initial begin
        mask_we = 1'b0; mask_wdata = '0; iack = 1'b0; iack_lvl = '0;
        sub_route = '0; ob_req = '0; sub_req = '0; rst = 1'b1;
        t_reset();
        t_channels();
        t_priority();
        t_masks();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule